// File: doc/BRIEF.md
# Five-Channel Register-Mapped PWM Controller

This block drives five independent pulse-width-modulated outputs from one clock. Software programs it through a small memory-mapped register bus with byte addresses, a write strobe, a read strobe and a registered read-data port. A single enable word at the bottom of the address map switches channels on and off, one bit per channel. Each channel then has its own window of registers, placed at a fixed stride. The window holds a control word, a period count and a high-time threshold.

Each channel divides the clock by a power of two, from 1 to 128. It counts prescaled ticks from zero up to one less than its period, then wraps. Its output is high while the count is below the threshold. The channel keeps a working copy of its settings, separate from the registers. That copy is refreshed while the channel is stopped and again at every period boundary. A reconfiguration therefore never cuts a cycle short.

Top module: `pwmc_top`

## Requirements
- R1: The byte map is as follows. The enable word sits at 0x000. Channel n (0 to 4) has its window base at 0x010 + n*0x040. Inside a window, the control word is at +0x00, the period at +0x2C and the threshold at +0x30. Read data appears on `bus_rdata` one clock after `bus_rd` is sampled and holds until the next read.
- R2: In the enable word, bit n enables channel n. A write replaces all five bits. A read returns them in bits 4:0, with zeros above.
- R3: In the control word, bits 2:0 hold k, which divides the clock by 2^k, and bit 15 is the run-mode bit. Only these bits are stored; the rest read as zero. Period and threshold are 13 bits each, in bits 12:0, with zeros above.
- R4: A running channel's counter walks 0 to P-1 in steps of one prescaled tick and then wraps. One period therefore lasts P*2^k clocks. A period of 0 behaves as a period of 1.
- R5: The output is high while count < T. Each period it is high for min(T,P)*2^k clocks. T = 0 gives a constant low, and T >= P gives a constant high.
- R6: A channel runs only while its enable bit and its run-mode bit are both 1. The change takes effect on the second rising edge after the write. A channel that is not running holds its prescaler and counter at 0 and drives its output low. A channel that starts again begins a new period at count 0.
- R7: Period, threshold and prescaler values written to a running channel take effect only at its next period boundary. The period in progress completes with the old values.
- R8: Reserved offsets inside a window (+0x04, +0x08, +0x0C, +0x28) and all unmapped addresses read as zero. Writes to them change no state.
- R9: Synchronous reset clears every register and the read data, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and all channels |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 5 | PWM outputs, bit n for channel n |

## Verification
The checker covers four channel rules on every cycle and every channel. A stopped channel keeps its output low. The counter stays inside the active period and advances at most one step at a time. The working settings never change except at count zero. It also checks that a reserved offset reads zero and that reset clears the ports. The exact high time per period under each prescaler, threshold and period combination can only be shown by the bench's measured windows. The same holds for the deferral of a mid-period threshold or prescaler change, and for the read-back masks of each register.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int PER_W    = 13;
    localparam int PSC_W    = 3;
    localparam int MODE_BIT = 15;
    // widest prescale divide is 2^(2^PSC_W - 1), counter needs that many bits
    localparam int PCNT_W   = (1 << PSC_W) - 1;

    // byte map
    localparam int EN_OFS     = 'h000;
    localparam int WIN_BASE   = 'h010;
    localparam int WIN_STRIDE = 'h040;
    localparam int CTRL_OFS   = 'h00;
    localparam int PER_OFS    = 'h2C;
    localparam int THR_OFS    = 'h30;

    typedef struct packed {
        logic             mode;
        logic [PSC_W-1:0] psc;
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] thresh;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PER,
        SEL_THR
    } ch_reg_e;

    // which register of window n an address hits, if any
    function automatic ch_reg_e decode_ch(input logic [ADDR_W-1:0] a, input int n);
        int off;
        off = int'(a) - (WIN_BASE + n * WIN_STRIDE);
        case (off)
            CTRL_OFS: return SEL_CTRL;
            PER_OFS:  return SEL_PER;
            THR_OFS:  return SEL_THR;
            default:  return SEL_NONE;
        endcase
    endfunction

    // terminal value of the prescale counter for divide-by-2^k
    function automatic logic [PCNT_W-1:0] tick_limit(input logic [PSC_W-1:0] k);
        return ~({PCNT_W{1'b1}} << k);
    endfunction

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NUM_CH-1:0]       en_mask,
    output ch_cfg_t [NUM_CH-1:0]    cfg
);

    logic [NUM_CH-1:0]    en_q;
    ch_cfg_t [NUM_CH-1:0] cfg_q;
    ch_reg_e              sel [NUM_CH];
    logic                 glb_hit;
    logic [DATA_W-1:0]    rd_val;
    logic [DATA_W-1:0]    rdata_q;

    // address decode: at most one target is hit
    always_comb begin
        glb_hit = (int'(bus_addr) == EN_OFS);
        for (int n = 0; n < NUM_CH; n++) begin
            sel[n] = decode_ch(bus_addr, n);
        end
    end

    // read mux, unmapped and reserved offsets fall through to zero
    always_comb begin
        rd_val = '0;
        if (glb_hit) begin
            rd_val[NUM_CH-1:0] = en_q;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            case (sel[n])
                SEL_CTRL: begin
                    rd_val[MODE_BIT]   = cfg_q[n].mode;
                    rd_val[PSC_W-1:0]  = cfg_q[n].psc;
                end
                SEL_PER:  rd_val[PER_W-1:0] = cfg_q[n].period;
                SEL_THR:  rd_val[PER_W-1:0] = cfg_q[n].thresh;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            cfg_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (bus_wr && glb_hit) begin
                en_q <= bus_wdata[NUM_CH-1:0];
            end
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_wr) begin
                    case (sel[n])
                        SEL_CTRL: begin
                            cfg_q[n].mode <= bus_wdata[MODE_BIT];
                            cfg_q[n].psc  <= bus_wdata[PSC_W-1:0];
                        end
                        SEL_PER:  cfg_q[n].period <= bus_wdata[PER_W-1:0];
                        SEL_THR:  cfg_q[n].thresh <= bus_wdata[PER_W-1:0];
                        default:  ;
                    endcase
                end
            end
            if (bus_rd) begin
                rdata_q <= rd_val;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign en_mask   = en_q;
    assign cfg       = cfg_q;

endmodule

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler
    import pwmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] lim;

    assign lim  = tick_limit(psc);
    assign tick = run && (pcnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel
    import pwmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  ch_cfg_t          pend,
    output logic             pwm,
    output logic             run,
    output logic [PER_W-1:0] count,
    output ch_cfg_t          active
);

    logic             run_q;
    ch_cfg_t          act_q;
    logic [PER_W-1:0] cnt_q;
    logic             tick;
    logic             wrap;

    pwmc_prescaler u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .psc  (act_q.psc),
        .tick (tick)
    );

    // last tick of the period; a zero period wraps on every tick
    assign wrap = tick && (((PER_W+1)'(cnt_q) + 1'b1) >= (PER_W+1)'(act_q.period));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            run_q <= enable & pend.mode;
            if (!run_q) begin
                cnt_q <= '0;
                act_q <= pend;
            end else if (tick) begin
                if (wrap) begin
                    cnt_q <= '0;
                    act_q <= pend;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pwm    = run_q && (cnt_q < act_q.thresh);
    assign run    = run_q;
    assign count  = cnt_q;
    assign active = act_q;

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]             en_mask;
    ch_cfg_t [NUM_CH-1:0]          cfg_pend;
    ch_cfg_t [NUM_CH-1:0]          ch_act;
    logic [NUM_CH-1:0]             ch_run;
    logic [NUM_CH-1:0][PER_W-1:0]  ch_cnt;

    pwmc_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .en_mask   (en_mask),
        .cfg       (cfg_pend)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmc_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .enable (en_mask[g]),
            .pend   (cfg_pend[g]),
            .pwm    (pwm_out[g]),
            .run    (ch_run[g]),
            .count  (ch_cnt[g]),
            .active (ch_act[g])
        );
    end

endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker
    import pwmc_pkg::*;
#(
    parameter int NUM_CH = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_rd,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0]            ch_run,
    input logic [NUM_CH-1:0][PER_W-1:0] ch_cnt,
    input ch_cfg_t [NUM_CH-1:0]         ch_act
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_out_low_R6: assert property (@(posedge clk) disable iff (rst)
            !ch_run[g] |-> !pwm_out[g]);

        assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
            ch_run[g] |-> (ch_cnt[g] == '0 || ch_cnt[g] < ch_act[g].period));

        assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
            (ch_run[g] && $past(ch_run[g])) |->
                (ch_cnt[g] == '0 || ch_cnt[g] == $past(ch_cnt[g])
                 || ch_cnt[g] == $past(ch_cnt[g]) + 1'b1));

        assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (ch_cnt[g] != '0) |-> $stable(ch_act[g]));
    end

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(4)) |=> (bus_rdata == '0));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && pwm_out == '0));

endmodule

bind pwmc_top pwmc_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_run    (ch_run),
    .ch_cnt    (ch_cnt),
    .ch_act    (ch_act)
);

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;
    import pwmc_pkg::*;

    localparam int NCH = 5;
    localparam int NV  = 9;
    localparam int V_PSC [NV] = '{0, 1, 2, 0, 3, 0, 7, 0, 0};
    localparam int V_PER [NV] = '{10, 8, 6, 5, 4, 1, 2, 0, 300};
    localparam int V_THR [NV] = '{3, 5, 0, 9, 2, 1, 1, 1, 299};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0]    pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwmc_top #(.NUM_CH(NCH)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic int addr_of(int ch, int ofs);
        return WIN_BASE + ch * WIN_STRIDE + ofs;
    endfunction

    // high clocks per period from R4/R5
    function automatic int exp_high(int psc, int per, int thr);
        int pe;
        pe = (per == 0) ? 1 : per;
        return ((thr < pe) ? thr : pe) << psc;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // all bus tasks start and end on a falling edge
    task automatic wr(int a, logic [31:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_addr = ADDR_W'(a);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic measure(int ch, int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) h++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h1, h2, ch, w;

        repeat (3) @(negedge clk);
        chk("R9", "rdata in reset", bus_rdata, 0);
        chk("R9", "outputs in reset", pwm_out, 0);
        rst = 1'b0;
        @(negedge clk);
        rd(EN_OFS, d);
        chk("R9", "enable after reset", d, 0);
        rd(addr_of(4, THR_OFS), d);
        chk("R9", "ch4 threshold after reset", d, 0);

        // R2: enable word keeps only five bits
        wr(EN_OFS, 32'hFFFF_FFF5);
        rd(EN_OFS, d);
        chk("R2", "enable readback", d, 32'h15);
        wr(EN_OFS, 32'h0);

        // R3: field masks on readback
        wr(addr_of(1, CTRL_OFS), 32'hFFFF_FFFF);
        rd(addr_of(1, CTRL_OFS), d);
        chk("R3", "control readback", d, 32'h8007);
        wr(addr_of(1, PER_OFS), 32'hFFFF_FFFF);
        rd(addr_of(1, PER_OFS), d);
        chk("R3", "period readback", d, 32'h1FFF);
        wr(addr_of(1, THR_OFS), 32'hFFFF_E005);
        rd(addr_of(1, THR_OFS), d);
        chk("R3", "threshold readback", d, 32'h5);

        // R1, R4, R5: vector table, channel v mod 5
        for (int v = 0; v < NV; v++) begin
            ch = v % NCH;
            wr(EN_OFS, 32'h0);
            wr(addr_of(ch, CTRL_OFS), 32'h8000 | V_PSC[v]);
            wr(addr_of(ch, PER_OFS), V_PER[v]);
            wr(addr_of(ch, THR_OFS), V_THR[v]);
            wr(EN_OFS, 32'(1) << ch);
            @(negedge clk);
            w = ((V_PER[v] == 0) ? 1 : V_PER[v]) << V_PSC[v];
            measure(ch, w, h1);
            measure(ch, w, h2);
            chk("R5", $sformatf("vector %0d first period high", v), h1,
                exp_high(V_PSC[v], V_PER[v], V_THR[v]));
            chk("R4", $sformatf("vector %0d second period high", v), h2,
                exp_high(V_PSC[v], V_PER[v], V_THR[v]));
        end
        wr(EN_OFS, 32'h0);

        // R8: reserved and unmapped writes ignored, reads zero
        wr(addr_of(0, CTRL_OFS), 32'h8002);
        wr(addr_of(0, 'h04), 32'hFFFF_FFFF);
        wr(addr_of(0, 'h28), 32'hFFFF_FFFF);
        wr('h004, 32'hFFFF_FFFF);
        wr('h200, 32'hFFFF_FFFF);
        rd(addr_of(0, 'h04), d);
        chk("R8", "reserved +0x04 read", d, 0);
        rd(addr_of(0, 'h28), d);
        chk("R8", "reserved +0x28 read", d, 0);
        rd('h200, d);
        chk("R8", "unmapped read", d, 0);
        rd(addr_of(0, CTRL_OFS), d);
        chk("R8", "control untouched", d, 32'h8002);
        rd(EN_OFS, d);
        chk("R8", "enable untouched", d, 0);

        // R6: run-mode bit clear keeps output low
        wr(addr_of(0, CTRL_OFS), 32'h0);
        wr(addr_of(0, PER_OFS), 4);
        wr(addr_of(0, THR_OFS), 4);
        wr(EN_OFS, 32'h1);
        @(negedge clk);
        measure(0, 8, h1);
        chk("R6", "mode bit clear high count", h1, 0);

        // R6: disable mid-run forces low on second edge
        wr(addr_of(0, CTRL_OFS), 32'h8000);
        @(negedge clk);
        @(negedge clk);
        chk("R6", "running before disable", pwm_out[0], 1);
        wr(EN_OFS, 32'h0);
        @(negedge clk);
        chk("R6", "low after disable", pwm_out[0], 0);

        // R7: mid-period threshold and prescaler changes deferred
        wr(addr_of(2, CTRL_OFS), 32'h8000);
        wr(addr_of(2, PER_OFS), 10);
        wr(addr_of(2, THR_OFS), 5);
        wr(EN_OFS, 32'h4);
        @(negedge clk);
        fork
            begin
                measure(2, 10, h1);
                measure(2, 20, h2);
            end
            begin
                repeat (3) @(negedge clk);
                wr(addr_of(2, THR_OFS), 8);
                wr(addr_of(2, CTRL_OFS), 32'h8001);
            end
        join
        chk("R7", "period in progress keeps old threshold", h1, 5);
        chk("R7", "next period uses new values", h2, 16);
        wr(EN_OFS, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule